// File: doc/BRIEF.md
# Bit-Serial Event Counter Bank

This block counts rising edges on a set of asynchronous event lines, one wide count per line. Each count is not a parallel binary counter. It lives in a shift register that rotates one bit per clock, least-significant bit first. A shared bit-phase sequencer marks the start and end of each word-time, and every channel has a one-bit serial adder with a carry flop. At the first bit of a word the adder takes a carry-in of one only when that channel has a pending event. The datapath clock therefore runs at word-width times the highest event rate. For example, 24-bit counts with events up to 2 MHz need a 48 MHz clock.

Each event line passes through a two-flop synchroniser and then a rising-edge detector. A detected edge sets a sticky pending flag, which the next word start consumes. A snapshot request can arrive at any time. At the next word boundary every fully updated count is copied into holding registers, and a one-cycle done pulse follows. A host reads the holding registers through a byte-wide port. It gives a channel number and a byte lane and pulses a read strobe. Each channel also has a status lane that reports and clears a sticky wrap flag.

Top module: `ecb_top`

## Requirements
- R1: Synchronous active-high reset clears all counts, pending flags, carries, overflow flags and holding registers. While reset is held and after it is released, snap_done_o and rd_data_o read 0 until a snapshot or read occurs.
- R2: Each rising edge on an event line adds exactly one to that channel's count, provided that successive rising edges on a line are at least CNT_W clocks apart and each high or low level lasts at least two clocks.
- R3: Channels count independently: events on one line never change the count or status of another.
- R4: A count wraps from all-ones to zero with no saturation, and the wrap sets that channel's sticky overflow flag.
- R5: A read of the status lane returns the overflow flag in bit 0, with bits 7:1 zero, and clears the flag. A second read with no new wrap in between returns 0.
- R6: A snapshot request is carried out at the next word boundary. snap_done_o pulses high for exactly one clock, between 1 and CNT_W clocks after the clock edge that samples the request.
- R7: Holding registers change only at a snapshot. Reads between snapshots return the last captured values even while counting continues.
- R8: Read mapping: lane 0 returns count bits 7:0, lane 1 bits 15:8 and lane 2 bits 23:16 of the held value. The highest lane code (3 for 24-bit counts, 1 for 8-bit counts) is the status lane. rd_data_o is updated on the clock edge that samples rd_stb_i and holds its value otherwise.
- R9: A line held high for many word-times counts once; only rising edges count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Datapath clock, CNT_W times the event rate |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_CH | Asynchronous event lines, one per channel |
| snap_req_i | input | 1 | Snapshot request, may be a single-cycle pulse |
| snap_done_o | output | 1 | One-cycle pulse after the holding registers are loaded |
| rd_ch_i | input | clog2(NUM_CH) | Channel to read |
| rd_lane_i | input | clog2(bytes+1) | Byte lane to read; highest code is status |
| rd_stb_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Registered read data |

## Verification
An event edge passes three synchroniser and edge flops and then waits up to one word-time for its increment, so the bench leaves two full word-times after the last event before it requests a snapshot. snap_done_o is due 1 to CNT_W clocks after the request is sampled. The bench counts falling edges from the request until the pulse appears, and then confirms the pulse is gone one clock later. Read data is due on the edge that samples the strobe, so the scoreboard monitor flags that edge and compares rd_data_o at the following falling edge against the value the driver queued.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

    // result of one serial add step
    typedef struct packed {
        logic sum;
        logic cout;
    } ecb_bit_t;

    function automatic ecb_bit_t ecb_add_bit(input logic a, input logic c);
        ecb_bit_t r;
        r.sum  = a ^ c;
        r.cout = a & c;
        return r;
    endfunction

    // number of byte lanes needed for a count width
    function automatic int ecb_bytes(input int w);
        return (w + 7) / 8;
    endfunction

    // lane select width: count lanes plus one status lane
    function automatic int ecb_lane_bits(input int w);
        return $clog2(ecb_bytes(w) + 1);
    endfunction

endpackage

// File: rtl/ecb_phase.sv
module ecb_phase #(
    parameter int CNT_W = 24
) (
    input  logic clk,
    input  logic rst,
    output logic first_o,
    output logic last_o
);
    localparam int PH_W = $clog2(CNT_W);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst)                           ph_q <= '0;
        else if (32'(ph_q) == CNT_W - 1)   ph_q <= '0;
        else                               ph_q <= ph_q + 1'b1;
    end

    assign first_o = (ph_q == '0);
    assign last_o  = (32'(ph_q) == CNT_W - 1);

    // R6: word boundaries recur, last bit is always followed by first
    p_phase_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        last_o |=> first_o);
    p_phase_range_r6: assert property (@(posedge clk) disable iff (rst)
        32'(ph_q) < CNT_W);

endmodule

// File: rtl/ecb_edge_pend.sv
module ecb_edge_pend (
    input  logic clk,
    input  logic rst,
    input  logic evt_async,
    input  logic first,
    output logic pend_o
);
    logic [2:0] sync_q;
    logic       rise;
    logic       pend_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], evt_async};
    end

    assign rise = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= rise | (pend_q & ~first);
    end

    assign pend_o = pend_q;

    // R2: an edge is never dropped before it is consumed
    p_edge_pend_r2: assert property (@(posedge clk) disable iff (rst)
        rise |=> pend_o);
    // R9: a steady level creates no new pending event
    p_level_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (first && $stable(sync_q[2]) && sync_q[2] && sync_q[1]) |=> !pend_o);

endmodule

// File: rtl/ecb_serial_lane.sv
module ecb_serial_lane
    import ecb_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             first,
    input  logic             last,
    input  logic             inc,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] word_o,
    output logic             ovf_o
);
    logic [CNT_W-1:0] sr_q;
    logic             cy_q;
    logic             ovf_q;
    ecb_bit_t         step;

    // carry-in at bit 0 is the pending event, elsewhere the carry flop
    always_comb step = ecb_add_bit(sr_q[0], first ? inc : cy_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cy_q  <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            sr_q  <= {step.sum, sr_q[CNT_W-1:1]};
            cy_q  <= step.cout;
            ovf_q <= (ovf_q & ~ovf_clr) | (last & step.cout);
        end
    end

    assign word_o = sr_q;
    assign ovf_o  = ovf_q;

    // R4: carry out of the top bit must leave the wrap flag set
    p_wrap_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (last && step.cout) |=> ovf_o);
    // R5: a status read clears the flag when no wrap coincides
    p_flag_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !(last && step.cout)) |=> !ovf_o);
    // R3: without a pending event the word at a boundary is unchanged a word later
    p_idle_word_r3: assert property (@(posedge clk) disable iff (rst)
        (first && !inc) |=> (sr_q[CNT_W-1] == $past(sr_q[0])));

endmodule

// File: rtl/ecb_top.sv
module ecb_top
    import ecb_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CNT_W  = 24
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_CH-1:0]               evt_i,
    input  logic                            snap_req_i,
    output logic                            snap_done_o,
    input  logic [$clog2(NUM_CH)-1:0]       rd_ch_i,
    input  logic [ecb_lane_bits(CNT_W)-1:0] rd_lane_i,
    input  logic                            rd_stb_i,
    output logic [7:0]                      rd_data_o
);
    localparam int NBYTES = ecb_bytes(CNT_W);
    localparam int LANE_W = ecb_lane_bits(CNT_W);
    localparam int STAT   = (1 << LANE_W) - 1;

    logic                first, last;
    logic [NUM_CH-1:0]   pend, ovf, ovf_clr;
    logic [CNT_W-1:0]    word [NUM_CH];
    logic [CNT_W-1:0]    hold_q [NUM_CH];
    logic                snap_pend_q, do_snap, done_q;
    logic                stat_rd;
    logic [CNT_W-1:0]    sel_word, shifted;
    logic [7:0]          rd_byte;

    ecb_phase #(.CNT_W(CNT_W)) phase_i (
        .clk(clk), .rst(rst), .first_o(first), .last_o(last)
    );

    assign stat_rd = rd_stb_i && (32'(rd_lane_i) == STAT);

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        ecb_edge_pend edge_i (
            .clk(clk), .rst(rst), .evt_async(evt_i[gi]),
            .first(first), .pend_o(pend[gi])
        );

        assign ovf_clr[gi] = stat_rd && (32'(rd_ch_i) == gi);

        ecb_serial_lane #(.CNT_W(CNT_W)) lane_i (
            .clk(clk), .rst(rst), .first(first), .last(last),
            .inc(pend[gi]), .ovf_clr(ovf_clr[gi]),
            .word_o(word[gi]), .ovf_o(ovf[gi])
        );

        always_ff @(posedge clk) begin
            if (rst)          hold_q[gi] <= '0;
            else if (do_snap) hold_q[gi] <= word[gi];
        end

        // R7: holding value moves only at a capture, flagged by the done pulse
        p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
            !snap_done_o |-> $stable(hold_q[gi]));
    end

    // snapshot: request is remembered until the next word boundary
    assign do_snap = first && (snap_pend_q || snap_req_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_pend_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            snap_pend_q <= (snap_pend_q || snap_req_i) && !do_snap;
            done_q      <= do_snap;
        end
    end

    assign snap_done_o = done_q;

    // read path
    always_comb begin
        sel_word = '0;
        if (32'(rd_ch_i) < NUM_CH) sel_word = hold_q[rd_ch_i];
        shifted = sel_word >> (32'(rd_lane_i) * 8);
        if (32'(rd_lane_i) < NBYTES)
            rd_byte = shifted[7:0];
        else if (32'(rd_lane_i) == STAT && 32'(rd_ch_i) < NUM_CH)
            rd_byte = {7'b0, ovf[rd_ch_i]};
        else
            rd_byte = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst)           rd_data_o <= 8'h00;
        else if (rd_stb_i) rd_data_o <= rd_byte;
    end

    // R6: a done pulse only follows a word boundary and lasts one clock
    p_snap_align_r6: assert property (@(posedge clk) disable iff (rst)
        snap_done_o |-> $past(first));
    p_snap_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        snap_done_o |=> !snap_done_o);
    // R8: read data holds without a strobe
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_stb_i |=> $stable(rd_data_o));

endmodule

// File: tb/ecb_top_tb_top.sv
module ecb_top_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [15:0] evt = '0;
    logic       snap = 1'b0;
    logic [3:0] rd_ch = '0;
    logic [1:0] rd_lane = '0;
    logic       rd_stb = 1'b0;
    logic       done_w;
    logic [7:0] rd_data;

    logic [1:0] evt_s = '0;
    logic       snap_s = 1'b0;
    logic       rd_ch_s = 1'b0;
    logic       rd_lane_s = 1'b0;
    logic       rd_stb_s = 1'b0;
    logic       done_s;
    logic [7:0] rd_data_s;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct {
        int         which;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    ecb_top dut_i (
        .clk(clk), .rst(rst), .evt_i(evt), .snap_req_i(snap),
        .snap_done_o(done_w), .rd_ch_i(rd_ch), .rd_lane_i(rd_lane),
        .rd_stb_i(rd_stb), .rd_data_o(rd_data)
    );

    ecb_top #(.NUM_CH(2), .CNT_W(8)) small_i (
        .clk(clk), .rst(rst), .evt_i(evt_s), .snap_req_i(snap_s),
        .snap_done_o(done_s), .rd_ch_i(rd_ch_s), .rd_lane_i(rd_lane_s),
        .rd_stb_i(rd_stb_s), .rd_data_o(rd_data_s)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare one clock after a sampled strobe
    logic due_b = 1'b0, due_s = 1'b0;
    always @(posedge clk) begin
        due_b <= rd_stb;
        due_s <= rd_stb_s;
    end
    always @(negedge clk) begin
        if (due_b || due_s) begin
            item_t it;
            if (sb_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R8 unexpected read actual=%0h expected=none", rd_data);
            end else begin
                it = sb_q.pop_front();
                check(it.tag, (it.which == 0) ? rd_data : rd_data_s, it.exp);
            end
        end
    end

    // driver: one read of the main instance
    task automatic rd_main(input int ch, input int lane, input logic [7:0] exp, input string tag);
        item_t it;
        it.which = 0; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        rd_ch = 4'(ch); rd_lane = 2'(lane); rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_small(input int ch, input int lane, input logic [7:0] exp, input string tag);
        item_t it;
        it.which = 1; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        rd_ch_s = 1'(ch); rd_lane_s = 1'(lane); rd_stb_s = 1'b1;
        @(negedge clk);
        rd_stb_s = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [15:0] m, input int hi, input int per);
        evt = m;
        repeat (hi) @(negedge clk);
        evt = '0;
        repeat (per - hi) @(negedge clk);
    endtask

    // R6: request, measure latency, confirm single-cycle pulse
    task automatic snapshot(input int which, input int wmax);
        int c;
        if (which == 0) snap = 1'b1; else snap_s = 1'b1;
        @(negedge clk);
        snap = 1'b0; snap_s = 1'b0;
        c = 1;
        while (((which == 0) ? done_w : done_s) == 1'b0 && c < 100) begin
            @(negedge clk);
            c++;
        end
        checks++;
        if (c < 1 || c > wmax) begin
            fails++;
            $display("FAIL R6 snapshot latency actual=%0d expected=1..%0d", c, wmax);
        end
        @(negedge clk);
        check("R6 done pulse width", (which == 0) ? done_w : done_s, 0);
    endtask

    int exp_cnt [16];

    task automatic read_all(input string tag);
        for (int ch = 0; ch < 16; ch++) begin
            rd_main(ch, 0, exp_cnt[ch][7:0],   {tag, " R2 R3 lane0"});
            rd_main(ch, 1, exp_cnt[ch][15:8],  {tag, " R8 lane1"});
            rd_main(ch, 2, exp_cnt[ch][23:16], {tag, " R8 lane2"});
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 done in reset", done_w, 0);
        check("R1 rd_data in reset", rd_data, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done after reset", done_w, 0);
        rd_main(0, 0, 8'h00, "R1 hold ch0 lane0");
        rd_main(9, 2, 8'h00, "R1 hold ch9 lane2");
        rd_main(4, 3, 8'h00, "R1 status ch4");

        // pattern A: channel i sees i edges
        for (int i = 0; i < 16; i++) exp_cnt[i] = 0;
        for (int r = 0; r < 16; r++) begin
            logic [15:0] m;
            m = '0;
            for (int i = 0; i < 16; i++) if (i > r) begin m[i] = 1'b1; exp_cnt[i]++; end
            pulse(m, 4, 48);
        end
        repeat (48) @(negedge clk);
        snapshot(0, 24);
        read_all("A");
        rd_main(12, 3, 8'h00, "R5 status clear ch12");

        // pattern B: counts continue, holding registers stay put
        for (int r = 0; r < 300; r++) begin
            logic [15:0] m;
            m = 16'h0008;
            if (r < 3) m[0] = 1'b1;
            if (r < 1) m[15] = 1'b1;
            pulse(m, 4, 48);
        end
        repeat (48) @(negedge clk);
        rd_main(3, 0, 8'(exp_cnt[3]), "R7 stale ch3 before snapshot");
        rd_main(0, 0, 8'(exp_cnt[0]), "R7 stale ch0 before snapshot");
        exp_cnt[3] += 300; exp_cnt[0] += 3; exp_cnt[15] += 1;
        snapshot(0, 24);
        read_all("B");

        // R9: long high level counts once
        evt[7] = 1'b1;
        repeat (300) @(negedge clk);
        evt[7] = 1'b0;
        repeat (60) @(negedge clk);
        exp_cnt[7] += 1;
        snapshot(0, 24);
        rd_main(7, 0, 8'(exp_cnt[7]), "R9 held level ch7");
        rd_main(6, 0, 8'(exp_cnt[6]), "R3 neighbour ch6");

        // R4/R5 on an 8-bit instance: 257 edges wrap to 1
        for (int r = 0; r < 257; r++) begin
            evt_s = 2'b01;
            repeat (4) @(negedge clk);
            evt_s = 2'b00;
            repeat (12) @(negedge clk);
        end
        repeat (20) @(negedge clk);
        snapshot(1, 8);
        rd_small(0, 0, 8'h01, "R4 wrap value");
        rd_small(1, 0, 8'h00, "R3 small ch1 value");
        rd_small(1, 1, 8'h00, "R3 small ch1 status");
        rd_small(0, 1, 8'h01, "R4 R5 overflow flag");
        rd_small(0, 1, 8'h00, "R5 flag cleared by read");

        repeat (4) @(negedge clk);
        check("R8 queue drained", sb_q.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule